// File: doc/BRIEF.md
# Two-Channel Prescaled PWM Controller

This block is a memory-mapped pulse-width modulator with two independent outputs. A host writes one shared control word and one period/duty word per channel over a plain 32-bit read/write strobe bus. Each channel has its own prescaler, which divides the input clock by an entry from a fixed non-power-of-two table. A reserved code freezes the channel, and a bypass bit forces divide-by-1. The prescaled ticks drive a period counter. The output is active while the count is below the duty value, and the active level is selectable.

New period/duty values land in a shadow register and raise a per-channel busy flag. The running counter picks them up only at the next period boundary, so a waveform never shows a torn period. A stopped or armed channel picks them up at once. Each channel has a small state machine with four states:
- `CH_STOP`: the output is idle.
- `CH_RUN`: the channel runs continuously.
- `CH_ARMED`: one-shot mode, waiting for a start.
- `CH_SHOT`: a single period is being emitted.

The state machine takes these transitions:
- STOP→RUN or STOP→ARMED when both enable and gate are set, the choice made by the mode bit.
- RUN→ARMED at a boundary when the mode bit is set.
- ARMED→RUN when the mode bit is cleared.
- ARMED→SHOT on a start request.
- SHOT→ARMED at the end of the period.
- Any state→STOP when enable or gate drops.

Top module: `pwm2_ctrl`

## Requirements
- R1: Byte address 0x0 selects the control word, and 0x4+4*n selects channel n's period/duty word. In a period/duty word, bits 31:16 are the period (ticks minus one) and bits 15:0 are the duty. Reads of a period/duty word return the values currently in use, one cycle after the read strobe.
- R2: Channel n's control field starts at bit 15*n:
  - code: bits 3:0
  - enable: bit 4
  - active-high: bit 5
  - gate: bit 6
  - one-shot mode: bit 7
  - start: bit 8
  - bypass: bit 9

  The busy flag of channel n is read-only at bit 28+n. All other control bits read as zero.
- R3: Codes 0..4 divide the clock by 120/180/240/360/480, codes 8..12 by 12000/24000/36000/48000/72000, and code 15 by 1. Each counter step lasts exactly that many clock cycles.
- R4: With the bypass bit set, the channel divides by 1 whatever its code.
- R5: While running, the count starts at 0, wraps after period+1 steps and the output is active while count < duty. Duty 0 gives a constant inactive level. Duty > period gives a constant active level.
- R6: Active-high 1 makes the active level 1. Active-high 0 inverts the output, making the active level 0.
- R7: Unless enable and gate are both 1, the channel is stopped, its output sits at the inactive level and its count restarts from 0 on the next start.
- R8: Reserved codes 5, 6, 7, 13 and 14 (without bypass) stop the ticks, so the counter and the output hold.
- R9: A period/duty write sets busy. The value is taken up at the next period boundary, or one cycle later if the channel is not running, and busy clears then.
- R10: A period/duty write while busy is ignored.
- R11: In one-shot mode an armed channel is inactive. Writing start=1 emits exactly one period, returns to armed and clears the start bit.
- R12: After reset, all registers read 0 and both outputs are 1, the inactive level with active-high 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe, data registered on the next edge |
| bus_addr | input | AW (4) | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data |
| pwm_out | output | NCH (2) | PWM outputs |

## Verification
The embedded properties watch the following on every cycle:
- the count never passes the period;
- a dropped enable or gate always lands in STOP;
- busy clears only at a boundary or while idle;
- the shadow never changes under a pending value;
- a reserved code never produces a tick;
- a finished shot always re-arms;
- the start bit clears only on completion or a host write.

Only the bench scenarios can show that the waveform has the right shape for each divider, period, duty and polarity. They also show the timing of the boundary take-up as seen through readback, and the one-period length of a shot.

// File: rtl/pwm2_pkg.sv
package pwm2_pkg;

    localparam int CNTW      = 16;   // period/duty counter width
    localparam int DIVW      = 17;   // prescaler counter width (72000 fits)
    localparam int FSTRIDE   = 15;   // channel field stride in control word
    localparam int BUSY_BASE = 28;   // first busy bit

    typedef enum logic [1:0] {
        CH_STOP  = 2'd0,
        CH_RUN   = 2'd1,
        CH_ARMED = 2'd2,
        CH_SHOT  = 2'd3
    } ch_state_e;

    // packed: first member is the MSB, so code lands in bits 3:0
    typedef struct packed {
        logic       bypass;
        logic       start;
        logic       oneshot;
        logic       gate;
        logic       act_hi;
        logic       en;
        logic [3:0] code;
    } ch_field_t;

    function automatic logic [DIVW-1:0] div_of(input logic [3:0] code);
        logic [DIVW-1:0] d;
        case (code)
            4'd0:    d = DIVW'(120);
            4'd1:    d = DIVW'(180);
            4'd2:    d = DIVW'(240);
            4'd3:    d = DIVW'(360);
            4'd4:    d = DIVW'(480);
            4'd8:    d = DIVW'(12000);
            4'd9:    d = DIVW'(24000);
            4'd10:   d = DIVW'(36000);
            4'd11:   d = DIVW'(48000);
            4'd12:   d = DIVW'(72000);
            4'd15:   d = DIVW'(1);
            default: d = '0;        // reserved: no tick
        endcase
        return d;
    endfunction

endpackage

// File: rtl/pwm2_prescaler.sv
module pwm2_prescaler
    import pwm2_pkg::*;
#(
    parameter int DW = pwm2_pkg::DIVW
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [3:0] code,
    input  logic       bypass,
    output logic       tick
);

    logic [DW-1:0] div;
    logic [DW-1:0] pcnt;
    logic          div_zero;

    always_comb begin
        div      = bypass ? DW'(1) : DW'(div_of(code));
        div_zero = (div == '0);
        // >= also recovers if the divider shrinks mid-count
        tick     = run && !div_zero && (pcnt >= div - DW'(1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pcnt <= '0;
        else if (!run)
            pcnt <= '0;
        else if (div_zero)
            pcnt <= pcnt;
        else if (tick)
            pcnt <= '0;
        else
            pcnt <= pcnt + DW'(1);
    end

    // R7: an idle prescaler restarts from zero
    p_idle_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (pcnt == '0));

endmodule

// File: rtl/pwm2_channel.sv
module pwm2_channel
    import pwm2_pkg::*;
#(
    parameter int CW = pwm2_pkg::CNTW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run_ok,
    input  logic            oneshot,
    input  logic            start_req,
    input  logic            act_hi,
    input  logic            tick,
    input  logic            wr_en,
    input  logic [2*CW-1:0] wr_data,
    output logic            pwm,
    output logic            busy,
    output logic            shot_done,
    output logic            running,
    output logic [CW-1:0]   prd_q,
    output logic [CW-1:0]   dty_q
);

    ch_state_e       st, nxt;
    logic [CW-1:0]   cnt;
    logic [2*CW-1:0] shd;
    logic            boundary;
    logic            nxt_active;
    logic            apply;
    logic            on;

    always_comb begin
        running  = (st == CH_RUN) || (st == CH_SHOT);
        boundary = running && tick && (cnt == prd_q);
        apply    = busy && (boundary || !running);
    end

    // next-state logic
    always_comb begin
        nxt = st;
        unique case (st)
            CH_STOP:  if (run_ok) nxt = oneshot ? CH_ARMED : CH_RUN;
            CH_RUN:   if (boundary && oneshot) nxt = CH_ARMED;
            CH_ARMED: if (start_req) nxt = CH_SHOT;
                      else if (!oneshot) nxt = CH_RUN;
            CH_SHOT:  if (boundary) nxt = CH_ARMED;
        endcase
        if (!run_ok) nxt = CH_STOP;
        nxt_active = (nxt == CH_RUN) || (nxt == CH_SHOT);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= CH_STOP;
        else        st <= nxt;
    end

    // counter and shadow datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            shd   <= '0;
            busy  <= 1'b0;
            prd_q <= '0;
            dty_q <= '0;
        end else begin
            if (!nxt_active || boundary) cnt <= '0;
            else if (tick)               cnt <= cnt + CW'(1);

            if (wr_en && !busy) begin
                shd  <= wr_data;
                busy <= 1'b1;
            end else if (apply) begin
                prd_q <= shd[2*CW-1:CW];
                dty_q <= shd[CW-1:0];
                busy  <= 1'b0;
            end
        end
    end

    // outputs
    always_comb begin
        on        = running && (cnt < dty_q);
        pwm       = act_hi ? on : !on;
        shot_done = (st == CH_SHOT) && boundary;
    end

    p_cnt_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (cnt <= prd_q));

    p_stop_on_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !run_ok |=> (st == CH_STOP));

    p_busy_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(boundary || !running));

    p_locked_shadow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_en) |=> $stable(shd));

    p_shot_rearm_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == CH_SHOT) && boundary && run_ok) |=> (st == CH_ARMED));

endmodule

// File: rtl/pwm2_ctrl.sv
module pwm2_ctrl
    import pwm2_pkg::*;
#(
    parameter int NCH = 2,
    parameter int AW  = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           bus_wr,
    input  logic           bus_rd,
    input  logic [AW-1:0]  bus_addr,
    input  logic [31:0]    bus_wdata,
    output logic [31:0]    bus_rdata,
    output logic [NCH-1:0] pwm_out
);

    localparam int FW = $bits(ch_field_t);

    ch_field_t [NCH-1:0]           fld;
    logic [NCH-1:0]                busy, shot_done, ch_run, tick, ch_wr;
    logic [NCH-1:0][CNTW-1:0]      prd_q, dty_q;
    logic                          ctrl_wr;
    logic [31:0]                   ctrl_word, rd_val;

    assign ctrl_wr = bus_wr && (bus_addr == AW'(0));

    // control fields; start bit self-clears on shot completion
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fld <= '0;
        end else begin
            for (int n = 0; n < NCH; n++) begin
                if (ctrl_wr)
                    fld[n] <= ch_field_t'(bus_wdata[FSTRIDE*n +: FW]);
                else if (shot_done[n])
                    fld[n].start <= 1'b0;
            end
        end
    end

    always_comb begin
        ctrl_word = '0;
        for (int n = 0; n < NCH; n++) begin
            ctrl_word[FSTRIDE*n +: FW] = fld[n];
            ctrl_word[BUSY_BASE+n]     = busy[n];
        end
        rd_val = '0;
        if (bus_addr == AW'(0)) rd_val = ctrl_word;
        for (int n = 0; n < NCH; n++)
            if (bus_addr == AW'(4*(n+1))) rd_val = {prd_q[n], dty_q[n]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_val;
    end

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        assign ch_wr[g] = bus_wr && (bus_addr == AW'(4*(g+1)));

        pwm2_prescaler #(.DW(DIVW)) u_pre (
            .clk    (clk),
            .rst_n  (rst_n),
            .run    (ch_run[g]),
            .code   (fld[g].code),
            .bypass (fld[g].bypass),
            .tick   (tick[g])
        );

        pwm2_channel #(.CW(CNTW)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .run_ok    (fld[g].en && fld[g].gate),
            .oneshot   (fld[g].oneshot),
            .start_req (fld[g].start),
            .act_hi    (fld[g].act_hi),
            .tick      (tick[g]),
            .wr_en     (ch_wr[g]),
            .wr_data   (bus_wdata),
            .pwm       (pwm_out[g]),
            .busy      (busy[g]),
            .shot_done (shot_done[g]),
            .running   (ch_run[g]),
            .prd_q     (prd_q[g]),
            .dty_q     (dty_q[g])
        );

        p_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_run[g] && !fld[g].bypass && (div_of(fld[g].code) == '0))
                |-> !tick[g]);

        p_start_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(fld[g].start) |-> $past(shot_done[g] || ctrl_wr));
    end

endmodule

// File: tb/tb_pwm2_ctrl.sv
module tb_pwm2_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  pwm_out;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    pwm2_ctrl dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .pwm_out(pwm_out)
    );

    function automatic logic [31:0] fw(input int ch, input int code,
        input bit en, input bit act, input bit gate, input bit one,
        input bit st, input bit byp);
        logic [31:0] v;
        v = 32'(code & 15) | (32'(en) << 4) | (32'(act) << 5) |
            (32'(gate) << 6) | (32'(one) << 7) | (32'(st) << 8) |
            (32'(byp) << 9);
        return v << (15 * ch);
    endfunction

    task automatic chk(input bit ok, input string tag,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bw(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic br(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // per-cycle waveform model, sample k is the k-th cycle after start
    task automatic wave(input int ch, input int prd, input int dty,
                        input int d, input bit act, input int n,
                        input string tag);
        int  err;
        int  c;
        bit  e;
        logic g;
        err = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            c = (k / d) % (prd + 1);
            e = act ? (c < dty) : !(c < dty);
            g = pwm_out[ch];
            if (g !== e) err++;
        end
        chk(err == 0, tag, err, 0);
    endtask

    task automatic setup(input int ch, input int prd, input int dty);
        bw(4'h0, 32'h0);
        bw(4'(4 + 4*ch), (32'(prd) << 16) | 32'(dty));
        idle(2);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        logic [31:0] rv;
        logic        first;
        int          err;

        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R12 reset state
        chk(pwm_out === 2'b11, "R12 reset outputs", pwm_out, 3);
        br(4'h0, rv); chk(rv === 0, "R12 reset ctrl", rv, 0);
        br(4'h4, rv); chk(rv === 0, "R12 reset ch0", rv, 0);
        br(4'h8, rv); chk(rv === 0, "R12 reset ch1", rv, 0);

        // R1 address map / readback of channel 1, stopped take-up
        bw(4'h8, 32'h0005_0003);
        idle(2);
        br(4'h8, rv); chk(rv === 32'h0005_0003, "R1 ch1 readback", rv, 32'h0005_0003);
        br(4'h4, rv); chk(rv === 0, "R1 ch0 untouched", rv, 0);

        // R2 field layout, reserved bits read zero
        bw(4'h0, 32'hF000_0000 | fw(0, 3, 0, 1, 0, 1, 0, 0) | fw(1, 9, 0, 0, 1, 0, 0, 1));
        br(4'h0, rv);
        chk(rv === (fw(0, 3, 0, 1, 0, 1, 0, 0) | fw(1, 9, 0, 0, 1, 0, 0, 1)),
            "R2 ctrl layout", rv, fw(0, 3, 0, 1, 0, 1, 0, 0) | fw(1, 9, 0, 0, 1, 0, 0, 1));

        // R5 sweep over period and duty, divide-by-1
        for (int p = 0; p < 4; p++) begin
            for (int du = 0; du < 6; du++) begin
                setup(0, p, du);
                bw(4'h0, fw(0, 15, 1, 1, 1, 0, 0, 0));
                wave(0, p, du, 1, 1'b1, 2*(p+1) + 3, "R5 sweep");
            end
        end

        // R3 small dividers, full two periods
        for (int c = 0; c < 5; c++) begin
            int dv;
            dv = (c == 0) ? 120 : (c == 1) ? 180 : (c == 2) ? 240 :
                 (c == 3) ? 360 : 480;
            setup(0, 1, 1);
            bw(4'h0, fw(0, c, 1, 1, 1, 0, 0, 0));
            wave(0, 1, 1, dv, 1'b1, 2*dv, "R3 divider");
        end
        // R3 large dividers, first step edge
        setup(0, 1, 1);
        bw(4'h0, fw(0, 8, 1, 1, 1, 0, 0, 0));
        wave(0, 1, 1, 12000, 1'b1, 12004, "R3 divider 12000");
        setup(0, 1, 1);
        bw(4'h0, fw(0, 12, 1, 1, 1, 0, 0, 0));
        wave(0, 1, 1, 72000, 1'b1, 72004, "R3 divider 72000");

        // R4 bypass on a reserved code gives divide-by-1
        setup(0, 3, 2);
        bw(4'h0, fw(0, 5, 1, 1, 1, 0, 0, 1));
        wave(0, 3, 2, 1, 1'b1, 12, "R4 bypass");

        // R6 dual channels, ch1 inverted
        bw(4'h0, 32'h0);
        bw(4'h4, 32'h0004_0003);
        bw(4'h8, 32'h0002_0001);
        idle(2);
        bw(4'h0, fw(0, 15, 1, 1, 1, 0, 0, 0) | fw(1, 15, 1, 0, 1, 0, 0, 0));
        begin
            int e0, e1;
            e0 = 0; e1 = 0;
            for (int k = 0; k < 30; k++) begin
                @(negedge clk);
                if (pwm_out[0] !== ((k % 5) < 3)) e0++;
                if (pwm_out[1] !== !((k % 3) < 1)) e1++;
            end
            chk(e0 == 0, "R6 ch0 normal", e0, 0);
            chk(e1 == 0, "R6 ch1 inverted", e1, 0);
        end

        // R7 gating: enable without gate, gate without enable
        setup(0, 3, 4);
        bw(4'h0, fw(0, 15, 1, 1, 0, 0, 0, 0));
        err = 0;
        for (int k = 0; k < 20; k++) begin @(negedge clk); if (pwm_out[0] !== 1'b0) err++; end
        chk(err == 0, "R7 no gate", err, 0);
        bw(4'h0, fw(0, 15, 0, 0, 1, 0, 0, 0));
        err = 0;
        for (int k = 0; k < 20; k++) begin @(negedge clk); if (pwm_out[0] !== 1'b1) err++; end
        chk(err == 0, "R7 no enable", err, 0);

        // R8 reserved code freezes
        setup(0, 9, 5);
        bw(4'h0, fw(0, 15, 1, 1, 1, 0, 0, 0));
        idle(3);
        bw(4'h0, fw(0, 13, 1, 1, 1, 0, 0, 0));
        first = pwm_out[0];
        err = 0;
        for (int k = 0; k < 40; k++) begin @(negedge clk); if (pwm_out[0] !== first) err++; end
        chk(err == 0, "R8 freeze", err, 0);

        // R9/R10 boundary take-up and locked shadow
        setup(0, 15, 2);
        bw(4'h0, fw(0, 15, 1, 1, 1, 0, 0, 0));
        bw(4'h4, 32'h0003_0001);
        br(4'h0, rv); chk(rv[28] === 1'b1, "R9 busy set", rv[28], 1);
        bw(4'h4, 32'h0005_0005);
        br(4'h4, rv); chk(rv === 32'h000F_0002, "R9 held to boundary", rv, 32'h000F_0002);
        idle(30);
        br(4'h4, rv); chk(rv === 32'h0003_0001, "R10 second write ignored", rv, 32'h0003_0001);
        br(4'h0, rv); chk(rv[28] === 1'b0, "R9 busy cleared", rv[28], 0);

        // R11 one-shot
        setup(0, 3, 2);
        bw(4'h0, fw(0, 15, 1, 1, 1, 1, 0, 0));
        err = 0;
        for (int k = 0; k < 8; k++) begin @(negedge clk); if (pwm_out[0] !== 1'b0) err++; end
        chk(err == 0, "R11 armed inactive", err, 0);
        bw(4'h0, fw(0, 15, 1, 1, 1, 1, 1, 0));
        err = 0;
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            if (pwm_out[0] !== (k < 2)) err++;
        end
        chk(err == 0, "R11 single period", err, 0);
        br(4'h0, rv); chk(rv[8] === 1'b0, "R11 start self-clear", rv[8], 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule